// File: doc/BRIEF.md
# Cipher Operation Timing Jitter Sequencer

This block sequences one block-cipher operation and hides its timing. A control write raises a start request that carries a key-size select and a jitter enable. The sequencer then waits for a random number of cycles, pulses a strobe that launches the cipher datapath, and holds a core phase whose length is fixed by the key size. It then waits for a second random number of cycles and reports completion. Because the start and the end of the operation both move from run to run, an attacker who averages power traces over many runs has a harder time lining them up.

The random delays come from an internal linear-feedback shift register. It advances on every clock and can be reseeded. The busy output tells other agents when the shared cryptographic memory must be left alone. Completion is reported by a sticky done flag, which software can poll, and by an interrupt level that depends on an enable. The cipher datapath itself lies outside this block.

Top module: `cjs_jitter_seq`

## Requirements
- R1: After reset the block is idle, with busy, done, error, interrupt and core-start all low. A start request with a valid key size while idle makes busy high from the next cycle and clears done.
- R2: With jitter enabled, the number of busy cycles before the core-start strobe equals bits [3:0] of the random register, sampled in the cycle the start request is accepted.
- R3: The core phase lasts 55 cycles for key select 2'b00 (128-bit), 70 cycles for 2'b01 (192-bit) and 75 cycles for 2'b10 (256-bit). It begins with the cycle in which core-start is high.
- R4: With jitter enabled, the number of busy cycles after the core phase equals bits [3:0] of the random register, sampled in the last cycle of the core phase.
- R5: With jitter disabled, both delays are zero: core-start is high in the first busy cycle, and busy lasts exactly the core length.
- R6: Done rises in the cycle after the last busy cycle. It stays high until the next accepted start request or a clear pulse.
- R7: The interrupt output is high exactly when done is high and the interrupt enable is high.
- R8: A start request that arrives while busy is ignored. It changes neither the duration of the operation nor its key size.
- R9: Key select 2'b11 is rejected. The block stays idle, done is left unchanged, and the error flag is set. The error flag clears on the next accepted start or on a clear pulse.
- R10: The random register is 16 bits wide. Its reset value is 16'hACE1. Each cycle it shifts left and feeds back bit15^bit13^bit12^bit10 into bit 0. A seed load replaces its content with the seed, and a zero seed is replaced with 16'h0001, so the register is never zero.
- R11: Core-start is a single-cycle pulse, and it occurs exactly once per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request from a control write |
| key_sel_i | input | 2 | Key-size select, sampled with start |
| jitter_en_i | input | 1 | Enables both random delays, sampled with start |
| irq_en_i | input | 1 | Interrupt enable |
| clr_done_i | input | 1 | Clears done and error |
| seed_load_i | input | 1 | Loads the random register from seed_i |
| seed_i | input | 16 | Seed value |
| core_start_o | output | 1 | One-cycle strobe that launches the cipher core |
| busy_o | output | 1 | Operation in progress; shared memory is in use |
| done_o | output | 1 | Sticky completion flag |
| irq_o | output | 1 | Completion interrupt level |
| key_err_o | output | 1 | Rejected key-size select |

## Verification
The bench keeps its own model of the random register. It predicts both delays from that model and measures them at the busy and core-start outputs, so a design that samples the register one cycle early or late, or that reuses the first value for the second delay, shows a wrong pre-delay or a wrong total length. Each key size is run with jitter off, which exposes off-by-one counts in the core phase: busy would then last 54 or 56 cycles instead of 55. A start that arrives mid-operation with a different key size would stretch or restart the run in a design that fails to ignore it. Further runs cover the rejected key code, a zero seed, and the clear path, where done, error and the interrupt must return low.

// File: rtl/cjs_pkg.sv
package cjs_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_PRE  = 2'd1,
      PH_CORE = 2'd2,
      PH_POST = 2'd3
   } cjs_phase_e;

   localparam logic [1:0] KSEL_128 = 2'b00;
   localparam logic [1:0] KSEL_192 = 2'b01;
   localparam logic [1:0] KSEL_256 = 2'b10;
   localparam logic [1:0] KSEL_BAD = 2'b11;
endpackage

// File: rtl/cjs_lfsr.sv
module cjs_lfsr #(
   parameter int          W        = 16,
   parameter logic [W-1:0] TAPS     = 16'hB400,
   parameter logic [W-1:0] RST_SEED = 16'hACE1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] seed_i,
   output logic [W-1:0] q_o
);
   localparam logic [W-1:0] ZERO_SUB = W'(1);

   logic [W-1:0] q;
   logic [W-1:0] tap_chain;
   logic         fb;

   initial begin
      assert (W >= 4) else $error("cjs_lfsr: width too small");
      assert (TAPS != '0) else $error("cjs_lfsr: empty tap mask");
      assert (RST_SEED != '0) else $error("cjs_lfsr: zero reset seed");
   end

   // feedback parity built bit by bit from the tap mask
   genvar b;
   generate
      for (b = 0; b < W; b++) begin : g_tap
         if (b == 0) begin : g_first
            assign tap_chain[b] = q[b] & TAPS[b];
         end else begin : g_rest
            assign tap_chain[b] = tap_chain[b-1] ^ (q[b] & TAPS[b]);
         end
      end
   endgenerate
   assign fb = tap_chain[W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RST_SEED;
      end else if (load_i) begin
         q <= (seed_i == '0) ? ZERO_SUB : seed_i;
      end else begin
         q <= {q[W-2:0], fb};
      end
   end

   assign q_o = q;

   // R10
   lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      q != '0);
endmodule

// File: rtl/cjs_down_timer.sv
module cjs_down_timer #(
   parameter int W = 7
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] val_i,
   output logic [W-1:0] cnt_o,
   output logic         zero_o
);
   logic [W-1:0] cnt;

   initial begin
      assert (W >= 1) else $error("cjs_down_timer: bad width");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load_i) begin
         cnt <= val_i;
      end else if (cnt != '0) begin
         cnt <= cnt - W'(1);
      end
   end

   assign cnt_o  = cnt;
   assign zero_o = (cnt == '0);
endmodule

// File: rtl/cjs_jitter_pick.sv
module cjs_jitter_pick #(
   parameter int RND_W   = 16,
   parameter int DLY_W   = 4,
   parameter bit PRESENT = 1'b1
) (
   input  logic [RND_W-1:0] rnd_i,
   input  logic             en_i,
   output logic [DLY_W-1:0] dly_o
);
   initial begin
      assert (DLY_W >= 1 && DLY_W <= RND_W) else $error("cjs_jitter_pick: bad delay width");
   end

   generate
      if (PRESENT) begin : g_jitter
         assign dly_o = en_i ? rnd_i[DLY_W-1:0] : '0;
      end else begin : g_fixed
         logic unused_in;
         assign unused_in = ^{rnd_i, en_i};
         assign dly_o     = '0;
      end
   endgenerate
endmodule

// File: rtl/cjs_jitter_seq.sv
module cjs_jitter_seq
   import cjs_pkg::*;
#(
   parameter int          RND_W          = 16,
   parameter logic [15:0] RND_TAPS       = 16'hB400,
   parameter logic [15:0] RND_RST_SEED   = 16'hACE1,
   parameter int          DLY_W          = 4,
   parameter bit          JITTER_PRESENT = 1'b1,
   parameter int          LEN_128        = 55,
   parameter int          LEN_192        = 70,
   parameter int          LEN_256        = 75
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [1:0]       key_sel_i,
   input  logic             jitter_en_i,
   input  logic             irq_en_i,
   input  logic             clr_done_i,
   input  logic             seed_load_i,
   input  logic [RND_W-1:0] seed_i,
   output logic             core_start_o,
   output logic             busy_o,
   output logic             done_o,
   output logic             irq_o,
   output logic             key_err_o
);
   localparam int MAX_LEN_A = (LEN_128 > LEN_192) ? LEN_128 : LEN_192;
   localparam int MAX_LEN   = (MAX_LEN_A > LEN_256) ? MAX_LEN_A : LEN_256;
   localparam int MAX_DLY   = (1 << DLY_W) - 1;
   localparam int MAX_CNT   = (MAX_LEN > MAX_DLY) ? MAX_LEN : MAX_DLY;
   localparam int CNT_W     = $clog2(MAX_CNT + 1);

   initial begin
      assert (LEN_128 >= 1 && LEN_192 >= 1 && LEN_256 >= 1)
         else $error("cjs_jitter_seq: core lengths must be positive");
      assert (RND_W == 16) else $error("cjs_jitter_seq: random register width fixed by taps");
      assert (DLY_W <= RND_W) else $error("cjs_jitter_seq: delay wider than random source");
   end

   function automatic logic [CNT_W-1:0] core_len(input logic [1:0] ks);
      case (ks)
         KSEL_192: core_len = CNT_W'(LEN_192);
         KSEL_256: core_len = CNT_W'(LEN_256);
         default:  core_len = CNT_W'(LEN_128);
      endcase
   endfunction

   cjs_phase_e       phase_q, phase_d;
   logic [1:0]       key_q;
   logic             jit_q;
   logic             done_q, err_q, cstart_q;
   logic             go, reject;
   logic             tmr_load, tmr_zero, done_set, enter_core;
   logic [CNT_W-1:0] tmr_val, tmr_cnt;
   logic [RND_W-1:0] rnd;
   logic [DLY_W-1:0] pre_dly, post_dly;

   cjs_lfsr #(
      .W        (RND_W),
      .TAPS     (RND_TAPS),
      .RST_SEED (RND_RST_SEED)
   ) u_rnd (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (seed_load_i),
      .seed_i (seed_i),
      .q_o    (rnd)
   );

   cjs_jitter_pick #(.RND_W(RND_W), .DLY_W(DLY_W), .PRESENT(JITTER_PRESENT)) u_pre (
      .rnd_i (rnd),
      .en_i  (jitter_en_i),
      .dly_o (pre_dly)
   );

   cjs_jitter_pick #(.RND_W(RND_W), .DLY_W(DLY_W), .PRESENT(JITTER_PRESENT)) u_post (
      .rnd_i (rnd),
      .en_i  (jit_q),
      .dly_o (post_dly)
   );

   cjs_down_timer #(.W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tmr_load),
      .val_i  (tmr_val),
      .cnt_o  (tmr_cnt),
      .zero_o (tmr_zero)
   );

   assign go     = start_i && (phase_q == PH_IDLE) && (key_sel_i != KSEL_BAD);
   assign reject = start_i && (phase_q == PH_IDLE) && (key_sel_i == KSEL_BAD);

   always_comb begin
      phase_d    = phase_q;
      tmr_load   = 1'b0;
      tmr_val    = '0;
      done_set   = 1'b0;
      enter_core = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (go) begin
               tmr_load = 1'b1;
               if (pre_dly != '0) begin
                  phase_d = PH_PRE;
                  tmr_val = CNT_W'(pre_dly) - CNT_W'(1);
               end else begin
                  phase_d    = PH_CORE;
                  tmr_val    = core_len(key_sel_i) - CNT_W'(1);
                  enter_core = 1'b1;
               end
            end
         end
         PH_PRE: begin
            if (tmr_zero) begin
               phase_d    = PH_CORE;
               tmr_load   = 1'b1;
               tmr_val    = core_len(key_q) - CNT_W'(1);
               enter_core = 1'b1;
            end
         end
         PH_CORE: begin
            if (tmr_zero) begin
               if (post_dly != '0) begin
                  phase_d  = PH_POST;
                  tmr_load = 1'b1;
                  tmr_val  = CNT_W'(post_dly) - CNT_W'(1);
               end else begin
                  phase_d  = PH_IDLE;
                  done_set = 1'b1;
               end
            end
         end
         PH_POST: begin
            if (tmr_zero) begin
               phase_d  = PH_IDLE;
               done_set = 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         key_q    <= KSEL_128;
         jit_q    <= 1'b0;
         cstart_q <= 1'b0;
      end else begin
         phase_q  <= phase_d;
         cstart_q <= enter_core;
         if (go) begin
            key_q <= key_sel_i;
            jit_q <= jitter_en_i;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         if (done_set)                done_q <= 1'b1;
         else if (go || clr_done_i)   done_q <= 1'b0;
         if (reject)                  err_q  <= 1'b1;
         else if (go || clr_done_i)   err_q  <= 1'b0;
      end
   end

   assign busy_o       = (phase_q != PH_IDLE);
   assign core_start_o = cstart_q;
   assign done_o       = done_q;
   assign irq_o        = done_q & irq_en_i;
   assign key_err_o    = err_q;

   // R1
   accept_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && key_sel_i != KSEL_BAD) |=> (busy_o && !done_o));

   // R6
   done_on_finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   // R8
   key_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (!busy_o || $stable(key_q)));

   // R9
   bad_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !busy_o && key_sel_i == KSEL_BAD) |=> (!busy_o && key_err_o));

   // R11
   cstart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |=> !core_start_o);

   // R11
   cstart_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_start_o |-> busy_o);

   // R3
   core_timer_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_CORE) |-> (tmr_cnt < CNT_W'(MAX_LEN)));
endmodule

// File: tb/cjs_jitter_seq_test.sv
module cjs_jitter_seq_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [1:0]  key_sel_i = 2'b00;
   logic        jitter_en_i = 1'b0;
   logic        irq_en_i = 1'b0;
   logic        clr_done_i = 1'b0;
   logic        seed_load_i = 1'b0;
   logic [15:0] seed_i = 16'h0000;
   logic        core_start_o, busy_o, done_o, irq_o, key_err_o;

   int checks = 0;
   int errors = 0;
   logic [15:0] m_rnd;

   always #5 clk = ~clk;

   cjs_jitter_seq uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .start_i      (start_i),
      .key_sel_i    (key_sel_i),
      .jitter_en_i  (jitter_en_i),
      .irq_en_i     (irq_en_i),
      .clr_done_i   (clr_done_i),
      .seed_load_i  (seed_load_i),
      .seed_i       (seed_i),
      .core_start_o (core_start_o),
      .busy_o       (busy_o),
      .done_o       (done_o),
      .irq_o        (irq_o),
      .key_err_o    (key_err_o)
   );

   // R10 model of the random register, taken from the requirement
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)           m_rnd <= 16'hACE1;
      else if (seed_load_i) m_rnd <= (seed_i == 16'h0) ? 16'h0001 : seed_i;
      else                  m_rnd <= {m_rnd[14:0], m_rnd[15] ^ m_rnd[13] ^ m_rnd[12] ^ m_rnd[10]};
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int len_of(input logic [1:0] k);
      return (k == 2'b00) ? 55 : (k == 2'b01) ? 70 : 75;
   endfunction

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      check("R1 reset busy", busy_o, 0);
      check("R1 reset done", done_o, 0);
      check("R1 reset err", key_err_o, 0);
      check("R1 reset irq", irq_o, 0);
      check("R1 reset core_start", core_start_o, 0);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // runs one operation; poke_idx >= 0 injects a start while busy (R8)
   task automatic t_op(input logic [1:0] key, input logic jit, input logic irq_en,
                       input int poke_idx);
      int L = len_of(key);
      int exp_pre, exp_post, cs_idx, pulses, idx;
      irq_en_i    = irq_en;
      key_sel_i   = key;
      jitter_en_i = jit;
      start_i     = 1'b1;
      exp_pre     = jit ? int'(m_rnd[3:0]) : 0;
      exp_post    = 0;
      @(negedge clk);
      start_i = 1'b0;
      check("R1 busy after start", busy_o, 1);
      check("R1 done cleared by start", done_o, 0);
      cs_idx = -1; pulses = 0; idx = 0;
      while (busy_o && idx < 400) begin
         if (core_start_o) begin
            pulses++;
            if (cs_idx < 0) cs_idx = idx;
         end
         if (cs_idx >= 0 && idx == cs_idx + L - 1)
            exp_post = jit ? int'(m_rnd[3:0]) : 0;
         if (idx == poke_idx) begin
            start_i = 1'b1; key_sel_i = 2'b10; jitter_en_i = 1'b1;
         end else begin
            start_i = 1'b0;
         end
         idx++;
         @(negedge clk);
      end
      start_i = 1'b0;
      if (jit) check("R2 pre-delay", cs_idx, exp_pre);
      else     check("R5 no pre-delay", cs_idx, 0);
      check("R11 one core_start pulse", pulses, 1);
      if (jit) check("R4 total with post-delay", idx, exp_pre + L + exp_post);
      else     check("R3 core length, R5 no jitter", idx, L);
      if (poke_idx >= 0) check("R8 start while busy ignored", idx, L);
      check("R6 done after finish", done_o, 1);
      check("R7 irq follows enable", irq_o, int'(irq_en));
      check("R9 err clear after valid op", key_err_o, 0);
   endtask

   task automatic t_bad_key();
      key_sel_i = 2'b11;
      start_i   = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      check("R9 bad key stays idle", busy_o, 0);
      check("R9 bad key error flag", key_err_o, 1);
      check("R9 bad key leaves done", done_o, 1);
      repeat (3) @(negedge clk);
      check("R9 still idle", busy_o, 0);
   endtask

   task automatic t_clear();
      irq_en_i   = 1'b1;
      clr_done_i = 1'b1;
      @(negedge clk);
      clr_done_i = 1'b0;
      check("R6 clear done", done_o, 0);
      check("R7 irq low after clear", irq_o, 0);
      check("R9 clear error", key_err_o, 0);
   endtask

   task automatic t_seed(input logic [15:0] s);
      seed_i = s; seed_load_i = 1'b1;
      @(negedge clk);
      seed_load_i = 1'b0;
      check("R10 seed sample", int'(m_rnd), (s == 16'h0) ? 1 : int'(s));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_op(2'b00, 1'b0, 1'b0, -1);   // R3 R5 128-bit
      t_op(2'b01, 1'b0, 1'b1, -1);   // R3 R7 192-bit
      t_op(2'b10, 1'b0, 1'b1, -1);   // R3 256-bit
      t_bad_key();                   // R9
      t_clear();                     // R6 R7 R9
      t_op(2'b00, 1'b1, 1'b1, -1);   // R2 R4
      t_op(2'b01, 1'b1, 1'b0, -1);
      t_op(2'b10, 1'b1, 1'b1, -1);
      t_op(2'b00, 1'b0, 1'b0, 10);   // R8
      t_seed(16'h0000);              // R10 zero seed
      t_op(2'b10, 1'b1, 1'b0, -1);
      t_seed(16'h5A3F);              // R10
      t_op(2'b01, 1'b1, 1'b1, -1);
      repeat (5) begin
         @(negedge clk);
         t_op(2'b00, 1'b1, 1'b1, -1);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule